// File: doc/BRIEF.md
# UART Receive Queue with DMA Request

This block is the receive-side buffer of one serial channel. The deserializer hands it each finished character as an 8-bit byte with three error flags and a one-cycle write strobe. The block keeps these as 11-bit entries in arrival order. The CPU or a DMA engine drains them through a show-ahead read port, and a line-status read clears the overrun indication.

In buffered mode the queue holds `DEPTH` entries. When buffering is disabled it acts as a single holding register, and the queue storage is reused with a capacity limit of one. The active-low receive-ready output has two modes. In single-transfer mode it requests service whenever any character is waiting. In multi-transfer mode it raises the request once the fill level reaches a programmed threshold, and holds it until the queue has been completely drained. The multi-transfer mode is only used while buffering is enabled.

Top module: `uart_rxq`

## Requirements
- R1: After reset `empty`=1, `full`=0, `level`=0, `overrun`=0, `rxrdy_n`=1, and `rd_data` and `rd_err` read as zero.
- R2: Entries leave in the order they were accepted. Each carries its own error flags on `rd_err` (bit 0 = parity, bit 1 = framing, bit 2 = break). `rd_data`/`rd_err` always show the oldest entry, and a cycle with `rd_en` high removes it.
- R3: With buffering enabled the queue reports `full` at `DEPTH` entries. A write while `full` is discarded without changing the stored entries, and `overrun` is 1 from the next cycle.
- R4: `lsr_rd` clears `overrun` on the next edge. If a discarded write and `lsr_rd` fall in the same cycle, `overrun` stays set.
- R5: With buffering disabled the capacity is one entry. A second write before a read is discarded and sets `overrun`.
- R6: In single-transfer mode (`dma_mode`=0) `rxrdy_n` is 0 exactly when `level` is at least 1.
- R7: In multi-transfer mode (`dma_mode`=1, buffering enabled) `rxrdy_n` falls when `level` reaches the threshold. It stays 0 while entries are read out below the threshold, and returns to 1 only when `level` is 0.
- R8: The threshold encoding is `trig_sel`=0 gives 1, 1 gives DEPTH/4, 2 gives DEPTH/2, and 3 gives DEPTH-2. With the default depth these are 1, 4, 8 and 14.
- R9: With buffering disabled, `rxrdy_n` follows the single-transfer rule whatever `dma_mode` and `trig_sel` hold.
- R10: A cycle with `fifo_clr` high empties the queue on that edge, and a write in the same cycle is dropped. Afterwards `rd_data` and `rd_err` read as zero, so no stale error flags remain.
- R11: Any change of `fifo_en` empties the queue on the following edge.
- R12: A read while empty is ignored: `level` stays 0 and later writes are read back correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 = buffered mode, 0 = single holding register |
| dma_mode | input | 1 | 0 = single-transfer request, 1 = multi-transfer request |
| trig_sel | input | 2 | Multi-transfer threshold select |
| fifo_clr | input | 1 | Synchronous queue flush |
| wr_en | input | 1 | Received-character strobe |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error flags: bit 0 parity, bit 1 framing, bit 2 break |
| rd_en | input | 1 | Remove the oldest entry |
| lsr_rd | input | 1 | Line-status read; clears overrun |
| rd_data | output | 8 | Oldest character (zero when empty) |
| rd_err | output | 3 | Error flags of the oldest character (zero when empty) |
| empty | output | 1 | No entry stored |
| full | output | 1 | Capacity reached for the current mode |
| level | output | $clog2(DEPTH+1) | Number of stored entries |
| overrun | output | 1 | A write was discarded since the last status read |
| rxrdy_n | output | 1 | Active-low receive-ready request |

## Verification
The bench builds the block with its default `DEPTH` of 16. This makes every threshold (1, 4, 8, 14) and the full boundary reachable within a few dozen writes. It also lets the queue wrap its pointers several times while a scoreboard queue of expected entries is compared against each popped entry. Threshold values sit just below and at each trigger, the set-versus-clear collision on the overrun flag is driven directly, and holding-register mode is entered with `dma_mode` left at 1 to show the mode fallback.

// File: rtl/uart_rxq_pkg.sv
// Package: shared widths and the entry type for the UART receive queue.
// Assumes an 8-bit character and three error flags per character.
package uart_rxq_pkg;
    localparam int RXQ_DATA_W = 8;
    localparam int RXQ_ERR_W  = 3;
    localparam int RXQ_ENT_W  = RXQ_DATA_W + RXQ_ERR_W;

    // One stored character: err[0] parity, err[1] framing, err[2] break.
    typedef struct packed {
        logic [RXQ_ERR_W-1:0]  err;
        logic [RXQ_DATA_W-1:0] data;
    } rxq_entry_t;
endpackage

// File: rtl/uart_rxq_store.sv
// Module: circular entry store with a mode-dependent capacity limit.
// Assumes DEPTH is a power of two of at least 4, so the pointers wrap
// naturally. A clear has priority over push and pop in the same cycle.
module uart_rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          cap_one,
    input  logic          push_req,
    input  rxq_entry_t    push_ent,
    input  logic          pop_req,
    output rxq_entry_t    head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          push_drop
);
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cap_lim;
    logic          do_push;
    logic          do_pop;
    rxq_entry_t    slots [DEPTH];

    // Capacity limit, full/empty flags and accepted operations.
    always_comb begin
        cap_lim   = cap_one ? CW'(1) : CW'(DEPTH);
        empty     = (cnt == '0);
        full      = (cnt >= cap_lim);
        do_push   = push_req && !full && !clr;
        do_pop    = pop_req && !empty && !clr;
        push_drop = push_req && full;
    end

    // Pointer and fill-count update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Entry storage; a flush wipes every slot so no error flag survives.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (do_push) begin
            slots[wr_ptr] <= push_ent;
        end
    end

    // Show-ahead head, forced to zero when nothing is stored.
    always_comb begin
        head = empty ? '0 : slots[rd_ptr];
    end

    assign count = cnt;
endmodule

// File: rtl/uart_rxq_trig.sv
// Module: decodes the two-bit threshold select into a fill level.
// Assumes DEPTH >= 4; a computed level below one is raised to one.
module uart_rxq_trig #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [1:0]    trig_sel,
    output logic [CW-1:0] trig_lvl
);
    localparam int LVL_Q = (DEPTH / 4 < 1) ? 1 : DEPTH / 4;
    localparam int LVL_H = (DEPTH / 2 < 1) ? 1 : DEPTH / 2;
    localparam int LVL_N = (DEPTH - 2 < 1) ? 1 : DEPTH - 2;

    // Threshold lookup.
    always_comb begin
        case (trig_sel)
            2'd0:    trig_lvl = CW'(1);
            2'd1:    trig_lvl = CW'(LVL_Q);
            2'd2:    trig_lvl = CW'(LVL_H);
            default: trig_lvl = CW'(LVL_N);
        endcase
    end
endmodule

// File: rtl/uart_rxq_dmareq.sv
// Module: receive-ready request generator for single and multi transfer.
// Assumes count and trig_lvl come from registers, so the output is glitch
// free one cycle after each fill change.
module uart_rxq_dmareq #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          multi,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] trig_lvl,
    output logic          rxrdy_n
);
    logic armed;
    logic nonempty;
    logic reach;
    logic active;

    // Request condition for the selected transfer style.
    always_comb begin
        nonempty = (count != '0);
        reach    = (count >= trig_lvl);
        active   = multi ? (nonempty && (armed || reach)) : nonempty;
        rxrdy_n  = !active;
    end

    // Remember a raised multi-transfer request until the queue drains.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= active && multi;
    end
endmodule

// File: rtl/uart_rxq.sv
// Module: top of the UART receive queue. It joins the store, the threshold
// decode and the request generator, and keeps the overrun flag.
// Assumes a mode change of fifo_en is handled as an implicit flush.
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fifo_en,
    input  logic                  dma_mode,
    input  logic [1:0]            trig_sel,
    input  logic                  fifo_clr,
    input  logic                  wr_en,
    input  logic [RXQ_DATA_W-1:0] wr_data,
    input  logic [RXQ_ERR_W-1:0]  wr_err,
    input  logic                  rd_en,
    input  logic                  lsr_rd,
    output logic [RXQ_DATA_W-1:0] rd_data,
    output logic [RXQ_ERR_W-1:0]  rd_err,
    output logic                  empty,
    output logic                  full,
    output logic [CW-1:0]         level,
    output logic                  overrun,
    output logic                  rxrdy_n
);
    logic          en_q;
    logic          flush;
    logic          drop;
    logic          ovr_q;
    logic [CW-1:0] trig_lvl;
    rxq_entry_t    in_ent;
    rxq_entry_t    head;

    // Explicit flush or a change of buffering mode empties the queue.
    always_comb begin
        flush       = fifo_clr || (fifo_en != en_q);
        in_ent.data = wr_data;
        in_ent.err  = wr_err;
    end

    // Track the previous buffering mode.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= fifo_en;
    end

    // Overrun flag: a discarded write sets it, a status read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)      ovr_q <= 1'b0;
        else if (drop)   ovr_q <= 1'b1;
        else if (lsr_rd) ovr_q <= 1'b0;
    end

    uart_rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (flush),
        .cap_one   (!fifo_en),
        .push_req  (wr_en),
        .push_ent  (in_ent),
        .pop_req   (rd_en),
        .head      (head),
        .count     (level),
        .empty     (empty),
        .full      (full),
        .push_drop (drop)
    );

    uart_rxq_trig #(.DEPTH(DEPTH)) u_trig (
        .trig_sel (trig_sel),
        .trig_lvl (trig_lvl)
    );

    uart_rxq_dmareq #(.CW(CW)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .multi    (fifo_en && dma_mode),
        .count    (level),
        .trig_lvl (trig_lvl),
        .rxrdy_n  (rxrdy_n)
    );

    assign rd_data = head.data;
    assign rd_err  = head.err;
    assign overrun = ovr_q;
endmodule

// File: rtl/uart_rxq_chk.sv
// Module: property checker for the UART receive queue, attached by bind.
// Assumes it only observes ports of the top module.
module uart_rxq_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          dma_mode,
    input logic          fifo_clr,
    input logic          wr_en,
    input logic          rd_en,
    input logic          lsr_rd,
    input logic          empty,
    input logic          full,
    input logic [CW-1:0] level,
    input logic          overrun,
    input logic          rxrdy_n
);
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH)); // R3
    AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> overrun); // R3
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !(wr_en && full)) |=> !overrun); // R4
    AST_CHAR_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && $stable(fifo_en)) |-> (level <= CW'(1))); // R5
    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en || !dma_mode) |-> (rxrdy_n == (level == '0))); // R6
    AST_MULTI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && dma_mode && $stable(fifo_en) && $stable(dma_mode)
         && $past(!rxrdy_n) && level != '0) |-> !rxrdy_n); // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> empty); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> empty); // R12
endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (fifo_en),
    .dma_mode (dma_mode),
    .fifo_clr (fifo_clr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .lsr_rd   (lsr_rd),
    .empty    (empty),
    .full     (full),
    .level    (level),
    .overrun  (overrun),
    .rxrdy_n  (rxrdy_n)
);

// File: tb/uart_rxq_test.sv
// Scoreboard bench for uart_rxq: the driver queues expected entries and a
// monitor compares every popped entry against the head of that queue.
module uart_rxq_test;
    localparam int DEPTH = 16;
    localparam int CW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_en = 1'b0;
    logic          dma_mode = 1'b0;
    logic [1:0]    trig_sel = 2'd0;
    logic          fifo_clr = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [2:0]    wr_err = '0;
    logic          rd_en = 1'b0;
    logic          lsr_rd = 1'b0;
    logic [7:0]    rd_data;
    logic [2:0]    rd_err;
    logic          empty;
    logic          full;
    logic [CW-1:0] level;
    logic          overrun;
    logic          rxrdy_n;

    int errors = 0;
    int checks = 0;
    logic [10:0] sb [$];

    always #10 clk = ~clk;

    uart_rxq #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
        .trig_sel(trig_sel), .fifo_clr(fifo_clr), .wr_en(wr_en),
        .wr_data(wr_data), .wr_err(wr_err), .rd_en(rd_en), .lsr_rd(lsr_rd),
        .rd_data(rd_data), .rd_err(rd_err), .empty(empty), .full(full),
        .level(level), .overrun(overrun), .rxrdy_n(rxrdy_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_eq(input string req, input string what,
                             input int act, input int exp);
        check(act == exp, req, what, act, exp);
    endtask

    // Driver: one write strobe; accepted entries go to the scoreboard.
    task automatic drive_wr(input logic [7:0] d, input logic [2:0] e,
                            input bit accept);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_err = e;
        if (accept) sb.push_back({e, d});
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drive_rd();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic fill(input int n, input int base);
        for (int i = 0; i < n; i++)
            drive_wr(8'(base + i), 3'(i), 1'b1);
    endtask

    task automatic drain();
        while (sb.size() != 0) drive_rd();
    endtask

    // Monitor: on each accepted pop, compare the head against the scoreboard (R2).
    always @(posedge clk) begin
        if (rst_n && rd_en && !empty && !fifo_clr) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "pop with empty scoreboard", int'(rd_data), -1);
            end else begin
                logic [10:0] exp_e;
                exp_e = sb.pop_front();
                expect_eq("R2", "popped data", int'(rd_data), int'(exp_e[7:0]));
                expect_eq("R2", "popped error flags", int'(rd_err), int'(exp_e[10:8]));
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        expect_eq("R1", "empty", int'(empty), 1);
        expect_eq("R1", "full", int'(full), 0);
        expect_eq("R1", "level", int'(level), 0);
        expect_eq("R1", "overrun", int'(overrun), 0);
        expect_eq("R1", "rxrdy_n", int'(rxrdy_n), 1);
        expect_eq("R1", "rd_data", int'(rd_data), 0);
        expect_eq("R1", "rd_err", int'(rd_err), 0);

        fifo_en = 1'b1;
        repeat (2) @(negedge clk);

        // R2 / R6: single-transfer request with mixed flags
        drive_wr(8'hA5, 3'b001, 1'b1);
        expect_eq("R6", "rxrdy_n at level 1", int'(rxrdy_n), 0);
        drive_wr(8'h3C, 3'b100, 1'b1);
        drive_wr(8'hFF, 3'b010, 1'b1);
        expect_eq("R2", "level after 3", int'(level), 3);
        drain();
        expect_eq("R6", "rxrdy_n when drained", int'(rxrdy_n), 1);

        // R12: read while empty is ignored
        drive_rd();
        expect_eq("R12", "level after empty read", int'(level), 0);
        drive_wr(8'h11, 3'b111, 1'b1);
        expect_eq("R12", "level after write", int'(level), 1);
        drain();

        // R3: full boundary and discarded write
        fill(DEPTH, 8'h40);
        expect_eq("R3", "full at DEPTH", int'(full), 1);
        expect_eq("R3", "overrun before drop", int'(overrun), 0);
        drive_wr(8'hEE, 3'b111, 1'b0);
        expect_eq("R3", "overrun after drop", int'(overrun), 1);
        expect_eq("R3", "level after drop", int'(level), DEPTH);
        drain();
        // R4: status read clears overrun
        @(negedge clk); lsr_rd = 1'b1;
        @(negedge clk); lsr_rd = 1'b0;
        expect_eq("R4", "overrun after status read", int'(overrun), 0);
        // R4: set wins over clear in the same cycle
        fill(DEPTH, 8'h80);
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h01; lsr_rd = 1'b1;
        @(negedge clk); wr_en = 1'b0; lsr_rd = 1'b0;
        expect_eq("R4", "overrun on collision", int'(overrun), 1);
        drain();
        @(negedge clk); lsr_rd = 1'b1;
        @(negedge clk); lsr_rd = 1'b0;

        // R7 / R8: multi-transfer thresholds
        dma_mode = 1'b1; trig_sel = 2'd1;
        fill(3, 8'h10);
        expect_eq("R8", "rxrdy_n below 4", int'(rxrdy_n), 1);
        drive_wr(8'h13, 3'b000, 1'b1);
        expect_eq("R8", "rxrdy_n at 4", int'(rxrdy_n), 0);
        repeat (3) drive_rd();
        expect_eq("R7", "rxrdy_n held at level 1", int'(rxrdy_n), 0);
        drive_rd();
        expect_eq("R7", "rxrdy_n released at empty", int'(rxrdy_n), 1);
        trig_sel = 2'd2;
        fill(7, 8'h20);
        expect_eq("R8", "rxrdy_n below 8", int'(rxrdy_n), 1);
        drive_wr(8'h27, 3'b101, 1'b1);
        expect_eq("R8", "rxrdy_n at 8", int'(rxrdy_n), 0);
        drain();
        expect_eq("R7", "rxrdy_n after drain", int'(rxrdy_n), 1);
        trig_sel = 2'd3;
        fill(13, 8'h60);
        expect_eq("R8", "rxrdy_n below 14", int'(rxrdy_n), 1);
        drive_wr(8'h6D, 3'b011, 1'b1);
        expect_eq("R8", "rxrdy_n at 14", int'(rxrdy_n), 0);
        drain();
        trig_sel = 2'd0;
        drive_wr(8'h77, 3'b000, 1'b1);
        expect_eq("R8", "rxrdy_n at threshold 1", int'(rxrdy_n), 0);
        drain();

        // R10: flush drops contents and a same-cycle write
        fill(3, 8'hC0);
        @(negedge clk); fifo_clr = 1'b1; wr_en = 1'b1; wr_data = 8'h99; wr_err = 3'b111;
        @(negedge clk); fifo_clr = 1'b0; wr_en = 1'b0;
        sb.delete();
        expect_eq("R10", "level after flush", int'(level), 0);
        expect_eq("R10", "rd_data after flush", int'(rd_data), 0);
        expect_eq("R10", "rd_err after flush", int'(rd_err), 0);
        expect_eq("R10", "rxrdy_n after flush", int'(rxrdy_n), 1);

        // R11: mode change empties the queue
        dma_mode = 1'b0;
        fill(2, 8'hD0);
        @(negedge clk); fifo_en = 1'b0;
        @(negedge clk);
        sb.delete();
        expect_eq("R11", "level after mode change", int'(level), 0);

        // R5 / R9: holding register, multi-transfer bits ignored
        dma_mode = 1'b1; trig_sel = 2'd3;
        drive_wr(8'h5A, 3'b010, 1'b1);
        expect_eq("R5", "full at one entry", int'(full), 1);
        expect_eq("R9", "rxrdy_n at level 1", int'(rxrdy_n), 0);
        drive_wr(8'hA6, 3'b001, 1'b0);
        expect_eq("R5", "overrun on second write", int'(overrun), 1);
        expect_eq("R5", "level stays 1", int'(level), 1);
        drain();
        expect_eq("R9", "rxrdy_n when empty", int'(rxrdy_n), 1);

        repeat (2) @(negedge clk);
        summary();
    end
endmodule